// File: doc/BRIEF.md
# DMA Status and Interrupt Summary Register

This block holds the event and process-state status of a descriptor-driven Ethernet DMA, together with its interrupt-enable register. The transmit and receive engines raise event bits through a one-cycle set vector and report their process states through load strobes. Software reads both registers through a small 32-bit port and clears event bits by writing ones to them.

Each event bit belongs either to the normal group or to the abnormal group. When any event in a group is both set and enabled, that group's summary bit is set. The summary bit stays set until software clears it. One level-sensitive interrupt line is high while an enabled summary bit is set. If software clears the receive-buffer-unavailable event, the receive state is forced to running-waiting and a one-cycle resume request goes to the receive engine.

Top module: `dma_stat_irq`

## Requirements
- R1: After reset, both registers read zero, both process states read stopped (0), and `irq`, `rx_resume` and `ro_write_err` are low.
- R2: A high bit on `evt_set` sets the matching status event bit (status bits 7:0) at the next clock edge. The bit then stays set until software clears it.
- R3: A write to the status register (`reg_addr`=0) clears each event bit and summary bit whose data bit is one. Bits written as zero keep their value.
- R4: If an engine sets an event bit in the same cycle that software clears it, the bit ends up set.
- R5: The normal summary (status bit 8) is set at the same edge at which any of event bits 0, 1, 2 or 7 becomes both set and enabled. It stays set after the event is cleared, and is cleared only by writing one to bit 8 while no enabled normal event remains set.
- R6: The abnormal summary (status bit 9) follows the same rule as R5 over event bits 3 to 6.
- R7: `irq` is high exactly when status bit 8 and enable bit 8 are both set, or status bit 9 and enable bit 9 are both set.
- R8: The receive state (status bits 12:10) and the transmit state (status bits 15:13) change only on their engine load strobes, which load the engine's value at the next edge. State codes are stopped=0, fetching=1, waiting=3, suspended=4, closing=5, transferring=7. Status writes from software do not change these bits, except as described in R9.
- R9: A status write with bit 3 set forces the receive state to waiting (3) at the next edge. If the receive engine's load strobe is active in the same cycle, the engine's value is loaded instead. `rx_resume` is high for one cycle after any such write.
- R10: A status write with any of bits 31:10 set leaves those bits unchanged and raises `ro_write_err` for one cycle after the write.
- R11: The enable register (`reg_addr`=1) stores written bits 9:0, with bit i enabling event i for i<8, bit 8 enabling the normal summary and bit 9 the abnormal summary. Bits 31:10 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| evt_set | input | 8 | One-cycle event set requests from the engines |
| rx_st_we | input | 1 | Receive engine state load strobe |
| rx_st_val | input | 3 | Receive engine state value |
| tx_st_we | input | 1 | Transmit engine state load strobe |
| tx_st_val | input | 3 | Transmit engine state value |
| irq | output | 1 | Level interrupt |
| rx_resume | output | 1 | One-cycle resume request to the receive engine |
| ro_write_err | output | 1 | One-cycle flag for a write to read-only status bits |

## Verification
The summary bits hold state that software never sees directly through `irq`. A summary bit that fails to stick would make `irq` drop one cycle after the event is cleared. A summary bit that fails to refold would keep `irq` low in the cycle right after an enabled event arrives. A wrong set-versus-clear priority, or a state field that drifts, shows up in the status read-back in the cycle after the stimulus. For that reason both registers, `irq` and the two pulses are compared against a reference model on every cycle, so any difference is caught one cycle after it arises.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  localparam int EVT_W_DEF = 8;
  localparam logic [EVT_W_DEF-1:0] NORM_MASK_DEF = 8'b1000_0111;
  localparam logic [EVT_W_DEF-1:0] ABN_MASK_DEF  = 8'b0111_1000;

  typedef enum logic [2:0] {
    PS_STOP  = 3'd0,
    PS_FETCH = 3'd1,
    PS_WAIT  = 3'd3,
    PS_SUSP  = 3'd4,
    PS_CLOSE = 3'd5,
    PS_XFER  = 3'd7
  } pstate_e;

  // next value of a bank of sticky bits: a set beats a clear
  function automatic logic [31:0] w1c_next(logic [31:0] q, logic [31:0] set,
                                           logic [31:0] clr);
    return set | (q & ~clr);
  endfunction

  // any bit of a group that is both pending and enabled
  function automatic logic group_hit(logic [31:0] evt, logic [31:0] en,
                                     logic [31:0] grp);
    return |(evt & en & grp);
  endfunction
endpackage

// File: rtl/dsi_evt_bank.sv
module dsi_evt_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] evt_d,
  output logic [W-1:0] evt_q
);
  assign evt_d = W'(dsi_pkg::w1c_next(32'(evt_q), 32'(set_i), 32'(clr_i)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    AST_EVT_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(evt_q[i]) |-> $past(clr_i[i])) else $error("evt fell without clear"); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(set_i[i]) |-> evt_q[i]) else $error("set lost"); // R4
  end
endmodule

// File: rtl/dsi_sum_fold.sv
module dsi_sum_fold #(
  parameter int W = 8,
  parameter logic [W-1:0] NORM = '0,
  parameter logic [W-1:0] ABN  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_d,
  input  logic [W-1:0] en_d,
  input  logic         nclr,
  input  logic         aclr,
  input  logic [1:0]   sum_en,
  output logic         nsum_q,
  output logic         asum_q,
  output logic         irq_o
);
  logic nhit, ahit, nsum_d, asum_d;

  assign nhit   = dsi_pkg::group_hit(32'(evt_d), 32'(en_d), 32'(NORM));
  assign ahit   = dsi_pkg::group_hit(32'(evt_d), 32'(en_d), 32'(ABN));
  assign nsum_d = nhit | (nsum_q & ~nclr);
  assign asum_d = ahit | (asum_q & ~aclr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nsum_q <= 1'b0;
      asum_q <= 1'b0;
    end else begin
      nsum_q <= nsum_d;
      asum_q <= asum_d;
    end
  end

  assign irq_o = (nsum_q & sum_en[0]) | (asum_q & sum_en[1]);

  AST_NSUM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nsum_q) |-> $past(nclr)) else $error("nsum fell"); // R5
  AST_ASUM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asum_q) |-> $past(aclr)) else $error("asum fell"); // R6
endmodule

// File: rtl/dsi_proc_state.sv
module dsi_proc_state #(
  parameter int ST_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eng_we,
  input  logic [ST_W-1:0] eng_val,
  input  logic            frc_we,
  input  logic [ST_W-1:0] frc_val,
  output logic [ST_W-1:0] st_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= ST_W'(dsi_pkg::PS_STOP);
    else if (eng_we) st_q <= eng_val;
    else if (frc_we) st_q <= frc_val;
  end

  AST_ST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(eng_we) && !$past(frc_we)) |-> $stable(st_q)) else $error("state drift"); // R8
  AST_ENG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eng_we) |-> (st_q == $past(eng_val))) else $error("state load"); // R8
endmodule

// File: rtl/dma_stat_irq.sv
module dma_stat_irq #(
  parameter int EVT_W  = dsi_pkg::EVT_W_DEF,
  parameter logic [EVT_W-1:0] NORM_MASK = dsi_pkg::NORM_MASK_DEF,
  parameter logic [EVT_W-1:0] ABN_MASK  = dsi_pkg::ABN_MASK_DEF,
  parameter int RU_BIT = 3,
  parameter int ST_W   = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [EVT_W-1:0]  evt_set,
  input  logic              rx_st_we,
  input  logic [ST_W-1:0]   rx_st_val,
  input  logic              tx_st_we,
  input  logic [ST_W-1:0]   tx_st_val,
  output logic              irq,
  output logic              rx_resume,
  output logic              ro_write_err
);
  localparam int NSUM_BIT = EVT_W;
  localparam int ASUM_BIT = EVT_W + 1;
  localparam int RW_W     = EVT_W + 2;
  localparam int RXS_LSB  = RW_W;
  localparam int TXS_LSB  = RXS_LSB + ST_W;
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_IEN  = 1'b1;
  localparam logic [DATA_W-1:0] LOW_ONES = DATA_W'((64'd1 << RW_W) - 64'd1);
  localparam logic [DATA_W-1:0] RO_MASK  = ~LOW_ONES;

  logic             stat_wr, ien_wr, ru_kick, ro_hit;
  logic [EVT_W-1:0] evt_clr, evt_d, evt_q;
  logic [RW_W-1:0]  ien_q, ien_d;
  logic             nsum_q, asum_q;
  logic [ST_W-1:0]  rx_st, tx_st;
  logic             resume_q, ro_err_q;

  // software decode
  assign stat_wr = reg_we && (reg_addr == ADDR_STAT);
  assign ien_wr  = reg_we && (reg_addr == ADDR_IEN);
  assign evt_clr = stat_wr ? reg_wdata[EVT_W-1:0] : '0;
  assign ru_kick = stat_wr && reg_wdata[RU_BIT];
  assign ro_hit  = stat_wr && |(reg_wdata & RO_MASK);
  assign ien_d   = ien_wr ? reg_wdata[RW_W-1:0] : ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q    <= '0;
      resume_q <= 1'b0;
      ro_err_q <= 1'b0;
    end else begin
      ien_q    <= ien_d;
      resume_q <= ru_kick;
      ro_err_q <= ro_hit;
    end
  end

  dsi_evt_bank #(.W(EVT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .set_i(evt_set), .clr_i(evt_clr),
    .evt_d(evt_d), .evt_q(evt_q)
  );

  dsi_sum_fold #(.W(EVT_W), .NORM(NORM_MASK), .ABN(ABN_MASK)) u_sum (
    .clk(clk), .rst_n(rst_n), .evt_d(evt_d), .en_d(ien_d[EVT_W-1:0]),
    .nclr(stat_wr && reg_wdata[NSUM_BIT]), .aclr(stat_wr && reg_wdata[ASUM_BIT]),
    .sum_en({ien_q[ASUM_BIT], ien_q[NSUM_BIT]}),
    .nsum_q(nsum_q), .asum_q(asum_q), .irq_o(irq)
  );

  dsi_proc_state #(.ST_W(ST_W)) u_rx_st (
    .clk(clk), .rst_n(rst_n), .eng_we(rx_st_we), .eng_val(rx_st_val),
    .frc_we(ru_kick), .frc_val(ST_W'(dsi_pkg::PS_WAIT)), .st_q(rx_st)
  );

  dsi_proc_state #(.ST_W(ST_W)) u_tx_st (
    .clk(clk), .rst_n(rst_n), .eng_we(tx_st_we), .eng_val(tx_st_val),
    .frc_we(1'b0), .frc_val('0), .st_q(tx_st)
  );

  // read mux
  logic [DATA_W-1:0] stat_word, ien_word;
  always_comb begin
    stat_word = '0;
    stat_word[EVT_W-1:0]       = evt_q;
    stat_word[NSUM_BIT]        = nsum_q;
    stat_word[ASUM_BIT]        = asum_q;
    stat_word[RXS_LSB +: ST_W] = rx_st;
    stat_word[TXS_LSB +: ST_W] = tx_st;
    ien_word = '0;
    ien_word[RW_W-1:0] = ien_q;
    reg_rdata = (reg_addr == ADDR_IEN) ? ien_word : stat_word;
  end

  assign rx_resume    = resume_q;
  assign ro_write_err = ro_err_q;

  AST_NSUM_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    |(evt_q & ien_q[EVT_W-1:0] & NORM_MASK) |-> nsum_q) else $error("nsum"); // R5
  AST_ASUM_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    |(evt_q & ien_q[EVT_W-1:0] & ABN_MASK) |-> asum_q) else $error("asum"); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_q[NSUM_BIT] && !ien_q[ASUM_BIT]) |-> !irq) else $error("irq"); // R7
  AST_RESUME_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_resume && !$past(rx_st_we)) |-> (rx_st == ST_W'(dsi_pkg::PS_WAIT)))
    else $error("resume"); // R9
  AST_RO_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    ro_write_err |-> $past(reg_we && (reg_addr == ADDR_STAT))) else $error("ro"); // R10
endmodule

// File: tb/dma_stat_irq_tb.sv
module dma_stat_irq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  evt_set = '0;
  logic        rx_st_we = 1'b0, tx_st_we = 1'b0;
  logic [2:0]  rx_st_val = '0, tx_st_val = '0;
  logic        irq, rx_resume, ro_write_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  logic [7:0] m_evt = '0;
  logic [9:0] m_en = '0;
  logic       m_ns = 0, m_as = 0, m_res = 0, m_ro = 0;
  logic [2:0] m_rx = '0, m_tx = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_stat_irq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
    .rx_st_we(rx_st_we), .rx_st_val(rx_st_val), .tx_st_we(tx_st_we),
    .tx_st_val(tx_st_val), .irq(irq), .rx_resume(rx_resume),
    .ro_write_err(ro_write_err)
  );

  function automatic logic is_normal(int i);
    return (i == 0) || (i == 1) || (i == 2) || (i == 7);
  endfunction

  function automatic logic [31:0] exp_status();
    return {16'h0, m_tx, m_rx, m_as, m_ns, m_evt};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    reg_we = 0;
    reg_addr = 0;
    #1 check(tag, "status", reg_rdata, exp_status());
    reg_addr = 1;
    #1 check(tag, "enable", reg_rdata, {22'h0, m_en});
    check(tag, "irq", 32'(irq), 32'((m_ns & m_en[8]) | (m_as & m_en[9])));
    check(tag, "rx_resume", 32'(rx_resume), 32'(m_res));
    check(tag, "ro_write_err", 32'(ro_write_err), 32'(m_ro));
  endtask

  task automatic model_edge();
    logic st_w, en_w, nhit, ahit;
    logic [7:0] ev_n;
    logic [9:0] en_n;
    st_w = reg_we && !reg_addr;
    en_w = reg_we && reg_addr;
    for (int i = 0; i < 8; i++)
      ev_n[i] = evt_set[i] ? 1'b1 : ((st_w && reg_wdata[i]) ? 1'b0 : m_evt[i]);
    en_n = en_w ? reg_wdata[9:0] : m_en;
    nhit = 0;
    ahit = 0;
    for (int i = 0; i < 8; i++) begin
      if (ev_n[i] && en_n[i]) begin
        if (is_normal(i)) nhit = 1;
        else              ahit = 1;
      end
    end
    m_ns = nhit || (m_ns && !(st_w && reg_wdata[8]));
    m_as = ahit || (m_as && !(st_w && reg_wdata[9]));
    if (rx_st_we)                   m_rx = rx_st_val;
    else if (st_w && reg_wdata[3])  m_rx = 3'd3;
    if (tx_st_we) m_tx = tx_st_val;
    m_res = st_w && reg_wdata[3];
    m_ro  = st_w && (reg_wdata[31:10] != 0);
    m_evt = ev_n;
    m_en  = en_n;
  endtask

  task automatic step(string tag, logic [7:0] set, logic we, logic addr,
                      logic [31:0] wd, logic rxwe, logic [2:0] rxv,
                      logic txwe, logic [2:0] txv);
    evt_set = set; reg_we = we; reg_addr = addr; reg_wdata = wd;
    rx_st_we = rxwe; rx_st_val = rxv; tx_st_we = txwe; tx_st_val = txv;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    evt_set = '0; rx_st_we = 0; tx_st_we = 0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all("R1 reset");
    // R11: only low ten bits of the enable register hold
    step("R11 enable width", 8'h00, 1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    // R2 R5 R7: normal event raises the summary and irq
    step("R2 R5 R7 normal set", 8'h01, 0, 0, 0, 0, 0, 0, 0);
    // R3 R5: clearing the event leaves the summary sticky
    step("R3 R5 sticky", 8'h00, 1, 0, 32'h0000_0001, 0, 0, 0, 0);
    // R3: writing zeros changes nothing
    step("R3 zero write", 8'h00, 1, 0, 32'h0000_0000, 0, 0, 0, 0);
    step("R5 R7 summary clear", 8'h00, 1, 0, 32'h0000_0100, 0, 0, 0, 0);
    // R4 R6 R9: set and clear of the unavailable bit in one cycle
    step("R4 R6 R9 collide", 8'h08, 1, 0, 32'h0000_0008, 0, 0, 1, 3'd5);
    // R6: summary clear while the enabled event remains set refolds
    step("R6 refold", 8'h00, 1, 0, 32'h0000_0200, 0, 0, 0, 0);
    // R9: engine strobe beats the forced waiting state
    step("R9 engine wins", 8'h00, 1, 0, 32'h0000_0008, 1, 3'd7, 0, 0);
    // R10 R8: read-only bits untouched, flag pulses
    step("R10 R8 ro write", 8'h00, 1, 0, 32'hFFFF_FC00, 0, 0, 0, 0);
    step("R10 flag drops", 8'h00, 0, 0, 0, 0, 0, 0, 0);
    // R7: summaries set but disabled keep irq low
    step("R7 masked", 8'h81, 1, 1, 32'h0000_00FF, 0, 0, 0, 0);
    step("R8 tx load", 8'h00, 0, 0, 0, 0, 0, 1, 3'd4);
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] s;
      logic we, ad;
      logic [31:0] wd;
      s  = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      we = ($urandom % 3 == 0);
      ad = 1'($urandom);
      wd = ($urandom % 8 == 0) ? $urandom : {22'h0, 10'($urandom)};
      step("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random", s, we, ad, wd,
           ($urandom % 8 == 0), 3'($urandom), ($urandom % 8 == 0), 3'($urandom));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule